// File: doc/BRIEF.md
# Directory Predicted-Upgrade Handler

This block sits at the home node of a directory-based coherent multiprocessor. It keeps the directory state of each line: Invalid, Shared or Exclusive, with one presence bit per node. It serves two kinds of request. A load miss records the requester as a sharer. An upgrade request asks for exclusive ownership of a line the requester already holds read-only. In parallel, the requester has already invalidated the nodes it predicted as sharers, and the upgrade carries that prediction as a node mask.

For an upgrade, the handler compares the prediction with the real sharer set and grades the result. It sends invalidations only to the sharers the prediction missed. It collects their acknowledgements and then returns an exclusive grant. The grant lists the real sharer set, so the requester can re-invalidate any node that refused the speculative invalidation and can train its predictor. Only one upgrade is outstanding at a time.

A load miss can carry a flag saying that the requester's copy was just taken away by a speculative invalidation. If that load names the line of the outstanding upgrade, and the directory still lists the requester as a sharer, the load is parked. It is replayed on the cycle after the upgrade retires, so that it cannot overtake the upgrade.

Top module: `dph_upgrade_home`

## Requirements
- R1: An upgrade to a Shared line is graded TOTAL HIT (class code 0) when every sharer other than the requester is set in the predicted mask. This includes the case where there is no other sharer. A TOTAL HIT issues no invalidation, and the exclusive grant appears in the same cycle as the class.
- R2: An upgrade to a Shared line is graded PARTIAL HIT (class code 1) when the prediction covers some, but not all, of the other sharers. The invalidation mask holds exactly the other sharers that were not predicted. The grant is withheld until all of those nodes have acknowledged.
- R3: An upgrade to a Shared line is graded TOTAL MISS (class code 2) when the prediction covers none of the other sharers. Every other sharer is invalidated, and the grant follows the last acknowledgement.
- R4: An upgrade to a line that is Invalid or Exclusive is graded NOT INV (class code 3), and the prediction is ignored. The invalidation mask is the current holder unless that holder is the requester. With no holder to invalidate, the grant is immediate.
- R5: Every upgrade grant has the exclusive flag set, addresses the requester, and carries the real set of other holders seen when the upgrade was accepted. Afterwards the line is Exclusive with the requester as its only holder.
- R6: A load miss that is not held back sets the Shared state and adds the requester's presence bit. A shared grant (exclusive flag clear) carrying the new presence vector appears one cycle after acceptance.
- R7: A load miss is parked without a reply when its Invalidated flag is set, it names the line of the outstanding upgrade, and the requester's presence bit is set. It is replayed on the cycle after that upgrade's grant, and it is answered like any other load. In that replay cycle the request port is not ready.
- R8: While an upgrade is outstanding, new upgrades are not accepted. Loads to the pending line that do not qualify for parking are also refused. Loads to other lines are served normally. No load is accepted in the cycle in which the outstanding upgrade retires.
- R9: An acknowledgement from a node that has no invalidation outstanding has no effect.
- R10: Reset leaves every line Invalid, all output valids low, and the request port ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_upg | input | 1 | 1 = upgrade request, 0 = load miss |
| req_node | input | NW | Requesting node |
| req_line | input | LW | Line index |
| req_pred | input | NODES | Predicted sharer mask (upgrades) |
| req_invd | input | 1 | Invalidated flag (loads) |
| ack_valid | input | 1 | Invalidation acknowledgement present |
| ack_node | input | NW | Node sending the acknowledgement |
| cls_valid | output | 1 | Upgrade class valid (one cycle) |
| cls_code | output | 2 | 0 total hit, 1 partial hit, 2 total miss, 3 not inv |
| inv_valid | output | 1 | Invalidation mask valid (one cycle) |
| inv_mask | output | NODES | Nodes to invalidate |
| rep_valid | output | 1 | Grant valid (one cycle) |
| rep_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| rep_node | output | NW | Node receiving the grant |
| rep_sharers | output | NODES | Real other-holder set (upgrade) or new presence vector (load) |

## Verification
The bench builds the block with four nodes and four lines. With that size, a short sequence of loads can drive every line through Invalid, Shared and Exclusive, and can produce each of the four upgrade classes with sharer sets that differ in every bit. The small node count also makes it practical to cover the parking case end to end. The bench holds an upgrade open and tries refused upgrades, refused loads, a served load to another line and an acknowledgement from a node with nothing outstanding. It then watches the parked load replay on the cycle after the grant.

// File: rtl/dph_pkg.sv
package dph_pkg;
  typedef enum logic [1:0] {
    CL_TOTAL_HIT  = 2'd0,
    CL_PARTIAL    = 2'd1,
    CL_TOTAL_MISS = 2'd2,
    CL_NOT_INV    = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    LS_INVALID = 2'd0,
    LS_SHARED  = 2'd1,
    LS_EXCL    = 2'd2
  } line_st_e;
endpackage

// File: rtl/dph_classify.sv
module dph_classify
  import dph_pkg::*;
#(
  parameter int NODES = 8
) (
  input  line_st_e           st,
  input  logic [NODES-1:0]   vec,
  input  logic [NODES-1:0]   req_bit,
  input  logic [NODES-1:0]   pred,
  output cls_e               cls,
  output logic [NODES-1:0]   others,
  output logic [NODES-1:0]   to_inv
);
  // Grade a prediction against the real set of other sharers.
  function automatic cls_e grade(input logic [NODES-1:0] oth,
                                 input logic [NODES-1:0] p);
    logic [NODES-1:0] hit;
    hit = oth & p;
    if (hit == oth)                   return CL_TOTAL_HIT;
    else if (hit == '0)               return CL_TOTAL_MISS;
    else                              return CL_PARTIAL;
  endfunction

  always_comb begin
    others = vec & ~req_bit;
    if (st == LS_SHARED) begin
      cls    = grade(others, pred);
      to_inv = others & ~pred;
    end else begin
      cls    = CL_NOT_INV;
      to_inv = others;
    end
  end
endmodule

// File: rtl/dph_ack_tracker.sv
module dph_ack_tracker #(
  parameter int NODES = 8,
  parameter int NW    = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [NODES-1:0] arm_mask,
  input  logic             ack_valid,
  input  logic [NW-1:0]    ack_node,
  output logic [NODES-1:0] pending,
  output logic             busy,
  output logic             done
);
  logic [NODES-1:0] ack_bit;
  logic             ack_hit;

  always_comb begin
    ack_bit = {{(NODES-1){1'b0}}, 1'b1} << ack_node;
    ack_hit = ack_valid && ((pending & ack_bit) != '0);
    done    = ack_hit && ((pending & ~ack_bit) == '0);
    busy    = (pending != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pending <= '0;
    else if (arm)      pending <= arm_mask;
    else if (ack_hit)  pending <= pending & ~ack_bit;
  end

  // R9: without arming, the outstanding set can only shrink
  p_pending_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> ((pending & ~$past(pending)) == '0));
endmodule

// File: rtl/dph_upgrade_home.sv
module dph_upgrade_home
  import dph_pkg::*;
#(
  parameter int NODES = 8,
  parameter int LINES = 16,
  parameter int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  parameter int LW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_upg,
  input  logic [NW-1:0]    req_node,
  input  logic [LW-1:0]    req_line,
  input  logic [NODES-1:0] req_pred,
  input  logic             req_invd,
  input  logic             ack_valid,
  input  logic [NW-1:0]    ack_node,
  output logic             cls_valid,
  output logic [1:0]       cls_code,
  output logic             inv_valid,
  output logic [NODES-1:0] inv_mask,
  output logic             rep_valid,
  output logic             rep_excl,
  output logic [NW-1:0]    rep_node,
  output logic [NODES-1:0] rep_sharers
);
  line_st_e         dir_st  [LINES];
  logic [NODES-1:0] dir_vec [LINES];

  logic             park_valid;
  logic [NW-1:0]    park_node;
  logic [LW-1:0]    park_line;
  logic [LW-1:0]    pend_line;
  logic [NW-1:0]    pend_node;
  logic [NODES-1:0] pend_others;

  logic             trk_busy, trk_done;
  logic [NODES-1:0] trk_pending;

  logic             replay, hit_pend, park_ok, accept;
  logic             do_load, do_park, do_upg, upg_now, upg_arm;
  logic [LW-1:0]    sel_line;
  logic [NW-1:0]    sel_node;
  logic [NODES-1:0] sel_bit, cur_vec, others, to_inv;
  line_st_e         cur_st;
  cls_e             cls;

  function automatic logic [NODES-1:0] node_bit(input logic [NW-1:0] n);
    return {{(NODES-1){1'b0}}, 1'b1} << n;
  endfunction

  always_comb begin
    replay   = park_valid && !trk_busy;
    sel_line = replay ? park_line : req_line;
    sel_node = replay ? park_node : req_node;
    sel_bit  = node_bit(sel_node);
    cur_st   = dir_st[sel_line];
    cur_vec  = dir_vec[sel_line];
    hit_pend = trk_busy && (req_line == pend_line);
    park_ok  = !req_upg && req_invd && hit_pend && !park_valid &&
               ((cur_vec & sel_bit) != '0);
    if (replay || trk_done) req_ready = 1'b0;
    else if (req_upg)       req_ready = !trk_busy;
    else                    req_ready = !hit_pend || park_ok;
    accept   = req_valid && req_ready;
    do_park  = accept && park_ok;
    do_load  = replay || (accept && !req_upg && !park_ok);
    do_upg   = accept && req_upg;
    upg_now  = do_upg && (to_inv == '0);
    upg_arm  = do_upg && (to_inv != '0);
  end

  dph_classify #(.NODES(NODES)) u_cls (
    .st(cur_st), .vec(cur_vec), .req_bit(sel_bit), .pred(req_pred),
    .cls(cls), .others(others), .to_inv(to_inv)
  );

  dph_ack_tracker #(.NODES(NODES), .NW(NW)) u_trk (
    .clk(clk), .rst_n(rst_n), .arm(upg_arm), .arm_mask(to_inv),
    .ack_valid(ack_valid), .ack_node(ack_node),
    .pending(trk_pending), .busy(trk_busy), .done(trk_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        dir_st[i]  <= LS_INVALID;
        dir_vec[i] <= '0;
      end
      park_valid  <= 1'b0;
      park_node   <= '0;
      park_line   <= '0;
      pend_line   <= '0;
      pend_node   <= '0;
      pend_others <= '0;
      cls_valid   <= 1'b0;
      cls_code    <= '0;
      inv_valid   <= 1'b0;
      inv_mask    <= '0;
      rep_valid   <= 1'b0;
      rep_excl    <= 1'b0;
      rep_node    <= '0;
      rep_sharers <= '0;
    end else begin
      cls_valid <= 1'b0;
      inv_valid <= 1'b0;
      rep_valid <= 1'b0;
      if (trk_done) begin
        dir_st[pend_line]  <= LS_EXCL;
        dir_vec[pend_line] <= node_bit(pend_node);
        rep_valid   <= 1'b1;
        rep_excl    <= 1'b1;
        rep_node    <= pend_node;
        rep_sharers <= pend_others;
      end
      if (do_park) begin
        park_valid <= 1'b1;
        park_node  <= req_node;
        park_line  <= req_line;
      end
      if (replay) park_valid <= 1'b0;
      if (do_load) begin
        dir_st[sel_line]  <= LS_SHARED;
        dir_vec[sel_line] <= cur_vec | sel_bit;
        rep_valid   <= 1'b1;
        rep_excl    <= 1'b0;
        rep_node    <= sel_node;
        rep_sharers <= cur_vec | sel_bit;
      end
      if (do_upg) begin
        cls_valid <= 1'b1;
        cls_code  <= cls;
      end
      if (upg_now) begin
        dir_st[sel_line]  <= LS_EXCL;
        dir_vec[sel_line] <= sel_bit;
        rep_valid   <= 1'b1;
        rep_excl    <= 1'b1;
        rep_node    <= sel_node;
        rep_sharers <= others;
      end
      if (upg_arm) begin
        pend_line   <= sel_line;
        pend_node   <= sel_node;
        pend_others <= others;
        inv_valid   <= 1'b1;
        inv_mask    <= to_inv;
      end
    end
  end

  // R1: a total hit grants at once and invalidates nothing
  p_hit_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_code == 2'd0) |-> (rep_valid && rep_excl && !inv_valid));
  // R2: a partial hit never re-invalidates a predicted node, and waits for acks
  p_unpred_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_code == 2'd1) |->
      (inv_valid && !rep_valid && ((inv_mask & $past(req_pred)) == '0)));
  // R3: a total miss invalidates before granting
  p_miss_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_code == 2'd2) |-> (inv_valid && !rep_valid));
  // R5: the grant sources never collide on the reply port
  p_one_reply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trk_done, do_load, upg_now}));
  // R7: a parked load is answered on the cycle after the upgrade retires
  p_replay_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (park_valid && $fell(trk_busy)) |=> (rep_valid && !rep_excl));
  // R8: invalidations are only issued from an idle handler
  p_inv_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !$past(trk_busy));
endmodule

// File: tb/sim_dph_upgrade_home.sv
`timescale 1ns/1ps
module sim_dph_upgrade_home;
  localparam int NODES = 4;
  localparam int LINES = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_upg = 1'b0, req_invd = 1'b0, ack_valid = 1'b0;
  logic [1:0] req_node = '0, req_line = '0, ack_node = '0;
  logic [3:0] req_pred = '0;
  logic req_ready, cls_valid, inv_valid, rep_valid, rep_excl;
  logic [1:0] cls_code, rep_node;
  logic [3:0] inv_mask, rep_sharers;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  dph_upgrade_home #(.NODES(NODES), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_upg(req_upg), .req_node(req_node), .req_line(req_line),
    .req_pred(req_pred), .req_invd(req_invd), .ack_valid(ack_valid),
    .ack_node(ack_node), .cls_valid(cls_valid), .cls_code(cls_code),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .rep_valid(rep_valid),
    .rep_excl(rep_excl), .rep_node(rep_node), .rep_sharers(rep_sharers)
  );

  typedef struct packed {
    logic       upg;
    logic [1:0] node;
    logic [1:0] line;
    logic [3:0] pred;
    logic [1:0] cls;
    logic [3:0] inv;
    logic [3:0] shr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b0, 2'd0, 2'd0, 4'b0000, 2'd0, 4'b0000, 4'b0001},
    '{1'b0, 2'd1, 2'd0, 4'b0000, 2'd0, 4'b0000, 4'b0011},
    '{1'b0, 2'd2, 2'd0, 4'b0000, 2'd0, 4'b0000, 4'b0111},
    '{1'b1, 2'd0, 2'd0, 4'b0110, 2'd0, 4'b0000, 4'b0110}, // R1
    '{1'b0, 2'd1, 2'd1, 4'b0000, 2'd0, 4'b0000, 4'b0010},
    '{1'b0, 2'd3, 2'd1, 4'b0000, 2'd0, 4'b0000, 4'b1010},
    '{1'b0, 2'd2, 2'd1, 4'b0000, 2'd0, 4'b0000, 4'b1110},
    '{1'b1, 2'd1, 2'd1, 4'b0100, 2'd1, 4'b1000, 4'b1100}, // R2
    '{1'b0, 2'd0, 2'd2, 4'b0000, 2'd0, 4'b0000, 4'b0001},
    '{1'b0, 2'd3, 2'd2, 4'b0000, 2'd0, 4'b0000, 4'b1001},
    '{1'b1, 2'd3, 2'd2, 4'b0110, 2'd2, 4'b0001, 4'b0001}, // R3
    '{1'b1, 2'd2, 2'd3, 4'b0011, 2'd3, 4'b0000, 4'b0000}, // R4 invalid line
    '{1'b0, 2'd1, 2'd3, 4'b0000, 2'd0, 4'b0000, 4'b0110}, // R6 from exclusive
    '{1'b1, 2'd0, 2'd0, 4'b1111, 2'd3, 4'b0000, 4'b0000}, // R4 own line
    '{1'b1, 2'd1, 2'd0, 4'b0000, 2'd3, 4'b0001, 4'b0001}, // R4 other owner
    '{1'b1, 2'd3, 2'd3, 4'b0010, 2'd1, 4'b0100, 4'b0110}  // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic u, input logic [1:0] n, input logic [1:0] l,
                       input logic [3:0] p, input logic f);
    req_valid = 1'b1; req_upg = u; req_node = n; req_line = l;
    req_pred = p; req_invd = f;
    #1;
  endtask

  task automatic idle_req();
    req_valid = 1'b0; req_upg = 1'b0; req_invd = 1'b0; req_pred = '0;
  endtask

  task automatic ack(input logic [1:0] n);
    ack_valid = 1'b1; ack_node = n;
    step();
    ack_valid = 1'b0;
  endtask

  task automatic chk_rep(input string tag, input logic x, input logic [1:0] n,
                         input logic [3:0] s);
    chk({tag, " reply valid"}, 32'(rep_valid), 32'd1);
    chk({tag, " reply excl"}, 32'(rep_excl), 32'(x));
    chk({tag, " reply node"}, 32'(rep_node), 32'(n));
    chk({tag, " reply sharers"}, 32'(rep_sharers), 32'(s));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 ready after reset", 32'(req_ready), 32'd1);
    chk("R10 valids after reset", 32'({cls_valid, inv_valid, rep_valid}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].upg, VT[i].node, VT[i].line, VT[i].pred, 1'b0);
      chk($sformatf("R8 ready vec %0d", i), 32'(req_ready), 32'd1);
      step();
      idle_req();
      if (!VT[i].upg) begin
        chk_rep($sformatf("R6 vec %0d", i), 1'b0, VT[i].node, VT[i].shr);
      end else begin
        chk($sformatf("R1-class vec %0d", i), 32'(cls_code), 32'(VT[i].cls));
        if (VT[i].inv == '0) begin
          chk($sformatf("R1 no inv vec %0d", i), 32'(inv_valid), 32'd0);
          chk_rep($sformatf("R5 vec %0d", i), 1'b1, VT[i].node, VT[i].shr);
        end else begin
          chk($sformatf("R2 inv mask vec %0d", i), 32'(inv_mask), 32'(VT[i].inv));
          chk($sformatf("R3 no early reply vec %0d", i), 32'(rep_valid), 32'd0);
          for (int b = 0; b < NODES; b++) begin
            if (VT[i].inv[b]) begin
              ack(2'(b));
              if ((VT[i].inv >> (b + 1)) != '0)
                chk($sformatf("R2 reply held vec %0d", i), 32'(rep_valid), 32'd0);
            end
          end
          chk_rep($sformatf("R5 vec %0d", i), 1'b1, VT[i].node, VT[i].shr);
        end
      end
    end

    // Directed: parking behind an outstanding upgrade on line 1 (owner n1)
    drive(1'b0, 2'd0, 2'd1, 4'b0000, 1'b0);
    step(); idle_req();
    chk_rep("R6 load on exclusive line", 1'b0, 2'd0, 4'b0011);
    drive(1'b1, 2'd0, 2'd1, 4'b0000, 1'b0);
    step(); idle_req();
    chk("R3 class total miss", 32'(cls_code), 32'd2);
    chk("R3 inv all others", 32'(inv_mask), 32'b0010);
    drive(1'b1, 2'd2, 2'd2, 4'b0000, 1'b0);
    chk("R8 upgrade refused while busy", 32'(req_ready), 32'd0);
    drive(1'b0, 2'd2, 2'd1, 4'b0000, 1'b0);
    chk("R8 unflagged load to pending line refused", 32'(req_ready), 32'd0);
    drive(1'b0, 2'd3, 2'd1, 4'b0000, 1'b1);
    chk("R7 flagged load from non-sharer refused", 32'(req_ready), 32'd0);
    drive(1'b0, 2'd1, 2'd1, 4'b0000, 1'b1);
    chk("R7 flagged sharer load accepted", 32'(req_ready), 32'd1);
    step(); idle_req();
    chk("R7 parked load not answered", 32'(rep_valid), 32'd0);
    drive(1'b0, 2'd2, 2'd2, 4'b0000, 1'b0);
    chk("R8 other line load ready", 32'(req_ready), 32'd1);
    step(); idle_req();
    chk_rep("R8 other line load served", 1'b0, 2'd2, 4'b1100);
    ack(2'd3);
    chk("R9 stray ack ignored", 32'(rep_valid), 32'd0);
    ack(2'd1);
    chk_rep("R5 grant after ack", 1'b1, 2'd0, 4'b0010);
    drive(1'b0, 2'd2, 2'd3, 4'b0000, 1'b0);
    chk("R7 ready low in replay cycle", 32'(req_ready), 32'd0);
    step(); idle_req();
    chk_rep("R7 replayed load", 1'b0, 2'd1, 4'b0011);
    drive(1'b0, 2'd2, 2'd3, 4'b0000, 1'b1);
    step(); idle_req();
    chk_rep("R6 flagged load with nothing pending", 1'b0, 2'd2, 4'b1100);
    // R1 with sole sharer: line 3 now {n2,n3}; n3 upgrades predicting n2
    drive(1'b1, 2'd3, 2'd3, 4'b0100, 1'b0);
    step(); idle_req();
    chk("R1 class total hit", 32'(cls_code), 32'd0);
    chk_rep("R1 immediate grant", 1'b1, 2'd3, 4'b0100);

    // Reset mid-run: directory returns to Invalid
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    drive(1'b1, 2'd0, 2'd0, 4'b0000, 1'b0);
    step(); idle_req();
    chk("R10 class after reset", 32'(cls_code), 32'd3);
    chk_rep("R10 empty line after reset", 1'b1, 2'd0, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule